// File: doc/BRIEF.md
# I2C Write-Only Target Receiver

This block is a bus target that accepts bytes written by an I2C controller using 7-bit addressing. It brings the SCL and SDA lines into the core clock domain and detects START and STOP conditions. It shifts in nine-clock byte frames and compares the address byte with a configured address. Every accepted byte, including the address byte, goes into a single holding register that the host reads.

When the holding register still holds a byte the host has not read, the next complete byte is refused. The register keeps its old contents, a sticky overflow flag is raised, and the target leaves SDA released on the acknowledge clock, so the controller sees a NACK. A per-byte interrupt flag rises at the end of every ninth clock while the target is addressed. Status outputs report whether the register is full, the R/W bit of the last address taken, and whether the last stored byte was address or data. The host clears the full flag by reading and clears the overflow and interrupt flags with explicit clear pulses.

Top module: `i2c_wr_target`

## Requirements
- R1: After a synchronous active-low reset, buffer-full, overflow, interrupt, last-R/W and last-was-data are all 0, the read data is 0x00 and SDA is not pulled.
- R2: Bytes are taken only after a START (SDA falling while SCL is high). After a STOP (SDA rising while SCL is high), clocked bytes are not acknowledged and change no flag.
- R3: When a byte completes while buffer-full is 1 and no host read happens in the same cycle, the overflow flag is set, the buffer keeps its previous value and the byte is not acknowledged.
- R4: An address byte whose upper 7 bits equal own_addr and whose bit 0 (R/W) is 0 is stored whole in the buffer. It sets buffer-full, clears last-was-data, sets last-R/W to 0, and is acknowledged.
- R5: Each data byte after an accepted address is stored with its first-received bit as bit 7. It sets buffer-full and last-was-data and is acknowledged.
- R6: The interrupt flag is set at the end of the ninth clock of every byte received while addressed, refused bytes included. It stays set until host_clr_irq is pulsed.
- R7: A host_rd pulse clears buffer-full. The overflow flag stays set through reads and is cleared only by host_clr_ovf.
- R8: An address byte with non-matching upper bits gets no ACK, no buffer load and no interrupt. The bytes that follow are ignored until the next START.
- R9: A matching address with R/W = 1 (a controller read) is not acknowledged, and the target ignores the bus until the next START.
- R10: A repeated START in the middle of a byte discards the partial byte and restarts address reception.
- R11: sda_pull (1 = drive SDA low) is asserted only during the ninth clock of an accepted byte, never during data bits and never while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| own_addr | input | 7 | Configured target address |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level (wired-AND bus value) |
| sda_pull | output | 1 | 1 pulls SDA low for ACK; 0 releases it |
| host_rd | input | 1 | One-cycle pulse: host reads the buffer |
| host_clr_ovf | input | 1 | One-cycle pulse: clear overflow flag |
| host_clr_irq | input | 1 | One-cycle pulse: clear interrupt flag |
| rd_data | output | 8 | Receive buffer contents |
| buf_full | output | 1 | Buffer holds an unread byte |
| ovf | output | 1 | Sticky overflow flag |
| irq | output | 1 | Per-byte interrupt flag |
| last_rw | output | 1 | R/W bit of the last stored address byte |
| last_was_data | output | 1 | 1 if the last stored byte was data, 0 if address |

## Verification
The receive path is driven with a matching write address, a data byte the host has consumed, and a data byte sent while the buffer is still unread. Together these separate a plain load from a refused load, and the ACK sampled on the wire shows the matching NACK. Non-matching addresses, a matching address with the read bit set, and bytes clocked after STOP check that the target stays silent whenever it is not addressed. An address broken off by a repeated START after three bits checks that partial shift state is discarded and the address that follows is stored intact.

// File: rtl/i2ct_pkg.sv
// Shared types for the I2C write-only target.
package i2ct_pkg;
    // Bus-side receive states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for START
        ST_RECV = 2'd1,   // shifting in eight bits
        ST_ACK  = 2'd2,   // ninth (acknowledge) clock
        ST_SKIP = 2'd3    // not addressed, wait for START
    } bus_state_t;
endpackage

// File: rtl/i2ct_line_sync.sv
// Line synchroniser and condition detector.
// Brings SCL and SDA through STAGES flip-flops each, then keeps one more
// registered copy to find SCL edges and START/STOP conditions.
// Assumes STAGES >= 2. Both lines reset to the idle (high) level so that
// reset release produces no spurious edge.
module i2ct_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // Metastability chain for both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    // One-cycle-old copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // Edge and condition decode.
    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/i2ct_rx_engine.sv
// Bus-side receive engine.
// Shifts in MSB-first bytes on SCL rising edges and judges each byte on the
// falling edge that closes bit eight. A matching write address or a data
// byte is then offered to the buffer. The ACK clock pulls SDA low only when
// the buffer accepted the byte. START restarts address reception from any
// state; STOP returns to idle.
// Assumes the condition inputs come from i2ct_line_sync.
module i2ct_rx_engine
    import i2ct_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              accept,
    output logic              byte_done,
    output logic [DATA_W-1:0] byte_val,
    output logic              byte_is_addr,
    output logic              ninth_end,
    output logic              sda_pull
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);

    bus_state_t        state;
    logic [CNT_W-1:0]  bitcnt;
    logic [DATA_W-1:0] shreg;
    logic              is_addr;
    logic              ack_en;
    logic              byte_end;
    logic              addr_ok;

    // Byte boundary and address judgement.
    always_comb begin
        byte_end  = (state == ST_RECV) && scl_fall && (bitcnt == FULL_CNT);
        addr_ok   = (shreg[DATA_W-1 -: ADDR_W] == own_addr) && !shreg[0];
        byte_done = byte_end && (!is_addr || addr_ok);
        ninth_end = (state == ST_ACK) && scl_fall;
    end

    assign byte_val     = shreg;
    assign byte_is_addr = is_addr;

    // Receive state machine, bit counter and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            is_addr <= 1'b0;
            ack_en  <= 1'b0;
        end else if (start_det) begin
            state   <= ST_RECV;
            bitcnt  <= '0;
            is_addr <= 1'b1;
            ack_en  <= 1'b0;
        end else if (stop_det) begin
            state   <= ST_IDLE;
            ack_en  <= 1'b0;
        end else begin
            case (state)
                ST_RECV: begin
                    if (scl_rise && (bitcnt < FULL_CNT)) begin
                        shreg  <= {shreg[DATA_W-2:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                    end
                    if (byte_end) begin
                        if (byte_done) begin
                            state  <= ST_ACK;
                            ack_en <= accept;
                        end else begin
                            state  <= ST_SKIP;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        state   <= ST_RECV;
                        bitcnt  <= '0;
                        is_addr <= 1'b0;
                        ack_en  <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // Open-drain acknowledge drive.
    assign sda_pull = (state == ST_ACK) && ack_en;

    p_ack_on_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && accept && !start_det && !stop_det) |=> sda_pull);

    p_nack_on_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && !accept) |=> !sda_pull);

    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_RECV && bitcnt == '0 && is_addr && !sda_pull));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull);
endmodule

// File: rtl/i2ct_rx_regs.sv
// Host-side receive buffer and flags.
// Holds one byte. A byte offered while the buffer is unread is refused and
// raises the sticky overflow flag. A host read in the same cycle as an
// offer frees the buffer first, so the offer is taken.
module i2ct_rx_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_done,
    input  logic [DATA_W-1:0] byte_val,
    input  logic              byte_is_addr,
    input  logic              ninth_end,
    input  logic              host_rd,
    input  logic              host_clr_ovf,
    input  logic              host_clr_irq,
    output logic              accept,
    output logic [DATA_W-1:0] rd_data,
    output logic              buf_full,
    output logic              ovf,
    output logic              irq,
    output logic              last_rw,
    output logic              last_was_data
);
    // Buffer is free when empty or being read this cycle.
    assign accept = !buf_full || host_rd;

    // Buffer contents and byte-type status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data       <= '0;
            last_rw       <= 1'b0;
            last_was_data <= 1'b0;
        end else if (byte_done && accept) begin
            rd_data       <= byte_val;
            last_was_data <= !byte_is_addr;
            if (byte_is_addr) last_rw <= byte_val[0];
        end
    end

    // Full flag: load sets, host read clears.
    always_ff @(posedge clk) begin
        if (!rst_n)                   buf_full <= 1'b0;
        else if (byte_done && accept) buf_full <= 1'b1;
        else if (host_rd)             buf_full <= 1'b0;
    end

    // Sticky overflow and interrupt flags; set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
            irq <= 1'b0;
        end else begin
            if (byte_done && !accept) ovf <= 1'b1;
            else if (host_clr_ovf)    ovf <= 1'b0;
            if (ninth_end)            irq <= 1'b1;
            else if (host_clr_irq)    irq <= 1'b0;
        end
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && !accept) |=> (ovf && $stable(rd_data) && buf_full));

    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && accept) |=> (buf_full && rd_data == $past(byte_val)));

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !host_clr_ovf) |=> ovf);

    p_irq_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !host_clr_irq) |=> irq);
endmodule

// File: rtl/i2c_wr_target.sv
// I2C write-only target, top level.
// Connects the line synchroniser, the receive engine and the host-side
// buffer. The caller resolves the open-drain SDA: sda_in must carry the
// wired-AND bus level including this block's own pull.
module i2c_wr_target #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    input  logic              host_rd,
    input  logic              host_clr_ovf,
    input  logic              host_clr_irq,
    output logic [DATA_W-1:0] rd_data,
    output logic              buf_full,
    output logic              ovf,
    output logic              irq,
    output logic              last_rw,
    output logic              last_was_data
);
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              accept, byte_done, byte_is_addr, ninth_end;
    logic [DATA_W-1:0] byte_val;

    i2ct_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2ct_rx_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .own_addr(own_addr), .accept(accept), .byte_done(byte_done),
        .byte_val(byte_val), .byte_is_addr(byte_is_addr),
        .ninth_end(ninth_end), .sda_pull(sda_pull)
    );

    i2ct_rx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .byte_val(byte_val),
        .byte_is_addr(byte_is_addr), .ninth_end(ninth_end), .host_rd(host_rd),
        .host_clr_ovf(host_clr_ovf), .host_clr_irq(host_clr_irq),
        .accept(accept), .rd_data(rd_data), .buf_full(buf_full), .ovf(ovf),
        .irq(irq), .last_rw(last_rw), .last_was_data(last_was_data)
    );

    // SCL level is kept for the synchroniser only.
    p_pull_needs_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_s);
endmodule

// File: tb/i2c_wr_target_bench.sv
module i2c_wr_target_bench;
    localparam int Q = 10;
    localparam logic [6:0] MY_ADDR = 7'h5A;   // write address byte 0xB4

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_drv = 1'b1;
    logic       host_rd = 1'b0, host_clr_ovf = 1'b0, host_clr_irq = 1'b0;
    logic       sda_pull, buf_full, ovf, irq, last_rw, last_was_data;
    logic [7:0] rd_data;
    wire        sda_line = sda_drv & ~sda_pull;

    int checks = 0;
    int errors = 0;
    bit pull_bad = 1'b0;
    bit ack;

    always #4 clk = ~clk;

    i2c_wr_target u_i2c_wr_target (
        .clk(clk), .rst_n(rst_n), .own_addr(MY_ADDR), .scl_in(scl),
        .sda_in(sda_line), .sda_pull(sda_pull), .host_rd(host_rd),
        .host_clr_ovf(host_clr_ovf), .host_clr_irq(host_clr_irq),
        .rd_data(rd_data), .buf_full(buf_full), .ovf(ovf), .irq(irq),
        .last_rw(last_rw), .last_was_data(last_was_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic start_cond();
        sda_drv = 1'b1; wq(); scl = 1'b1; wq();
        sda_drv = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic stop_cond();
        sda_drv = 1'b0; wq(); scl = 1'b1; wq(); sda_drv = 1'b1; wq();
    endtask

    task automatic send_bit(input bit b);
        sda_drv = b; wq(); scl = 1'b1; wq();
        if (sda_pull) pull_bad = 1'b1;
        wq(); scl = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_drv = 1'b1; wq(); scl = 1'b1; wq();
        acked = !sda_line;
        wq(); scl = 1'b0; wq();
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) host_rd = 1'b1;
        if (which == 1) host_clr_ovf = 1'b1;
        if (which == 2) host_clr_irq = 1'b1;
        @(negedge clk);
        host_rd = 1'b0; host_clr_ovf = 1'b0; host_clr_irq = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(!buf_full && !ovf && !irq && !last_rw && !last_was_data, "R1 flags",
            {buf_full, ovf, irq, last_rw, last_was_data}, 0);
        chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
        chk(!sda_pull, "R1 sda_pull", sda_pull, 0);
    endtask

    task automatic t_addr_match();
        start_cond();
        send_byte({MY_ADDR, 1'b0}, ack);
        chk(ack, "R4 addr ack", ack, 1);
        chk(rd_data == 8'hB4, "R4 addr stored", rd_data, 8'hB4);
        chk(buf_full && !last_was_data && !last_rw, "R4 status",
            {buf_full, last_was_data, last_rw}, 3'b100);
        chk(irq, "R6 irq after addr", irq, 1);
        pulse(0);
        chk(!buf_full, "R7 read clears full", buf_full, 0);
        pulse(2);
        chk(!irq, "R6 irq cleared", irq, 0);
    endtask

    task automatic t_data_and_overflow();
        send_byte(8'h3C, ack);
        chk(ack, "R5 data ack", ack, 1);
        chk(rd_data == 8'h3C && last_was_data && buf_full, "R5 data stored",
            {rd_data, last_was_data, buf_full}, {8'h3C, 2'b11});
        chk(irq, "R6 irq after data", irq, 1);
        pulse(2);
        send_byte(8'h99, ack);
        chk(!ack, "R3 nack on overflow", ack, 0);
        chk(ovf, "R3 ovf set", ovf, 1);
        chk(rd_data == 8'h3C, "R3 buffer kept", rd_data, 8'h3C);
        chk(irq, "R6 irq on refused byte", irq, 1);
        pulse(0);
        chk(!buf_full && ovf, "R7 ovf survives read", {buf_full, ovf}, 2'b01);
        pulse(1);
        chk(!ovf, "R7 ovf cleared", ovf, 0);
        pulse(2);
        stop_cond();
        chk(!sda_pull, "R11 idle no pull", sda_pull, 0);
        chk(!pull_bad, "R11 no pull during data bits", pull_bad, 0);
    endtask

    task automatic t_after_stop();
        send_byte({MY_ADDR, 1'b0}, ack);
        chk(!ack && !irq && !buf_full, "R2 ignored after stop",
            {ack, irq, buf_full}, 0);
    endtask

    task automatic t_nomatch();
        start_cond();
        send_byte(8'h22, ack);
        chk(!ack && !irq && !buf_full, "R8 nomatch addr", {ack, irq, buf_full}, 0);
        send_byte(8'h55, ack);
        chk(!ack && !irq && !buf_full && rd_data == 8'h3C, "R8 data ignored",
            {ack, irq, buf_full}, 0);
        stop_cond();
    endtask

    task automatic t_read_dir();
        start_cond();
        send_byte({MY_ADDR, 1'b1}, ack);
        chk(!ack && !irq && !buf_full, "R9 read addr ignored", {ack, irq, buf_full}, 0);
        stop_cond();
    endtask

    task automatic t_restart();
        start_cond();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        start_cond();
        send_byte({MY_ADDR, 1'b0}, ack);
        chk(ack && rd_data == 8'hB4 && !last_was_data, "R10 repeated start",
            {ack, rd_data, last_was_data}, {1'b1, 8'hB4, 1'b0});
        pulse(0); pulse(2);
        stop_cond();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_addr_match();
        t_data_and_overflow();
        t_after_stop();
        t_nomatch();
        t_read_dir();
        t_restart();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule